// File: doc/BRIEF.md
# Epoch-Based Interconnect Feature Governor

This block is the central controller that decides, once per epoch, which of three optional router features an on-chip network should run with: router power gating, output-port prediction and traffic compression. It runs the network in a repeating cycle. First comes a measurement window in which every feature is switched on and six event pulse streams from the network are counted. A short computation phase follows, in which a fixed-point latency and dynamic-energy model is evaluated from those counts. Last comes an execution epoch, during which each feature stays on only if the model predicted a net gain for it.

Both the window and the epoch are measured in retired instructions, which arrive as a one-bit pulse, not in clock cycles. The model coefficients are parameters in unsigned fixed point with 8 fractional bits (Q8, so 256 means 1.0). The per-flit ratios the model needs come from one shared sequential divider. All model arithmetic is exact integer arithmetic, so the decisions can be predicted bit for bit.

Top module: `noc_feature_governor`

## Requirements
- R1: A synchronous active-high `rst` starts a fresh measurement window. In the cycle after a reset edge, all three enable outputs read 1.
- R2: Throughout the measurement window and the computation phase, all three enables are 1. The window closes on the clock edge that counts its WIN_LEN-th `instr_ret` pulse.
- R3: The six event inputs (flit, hop, prediction, prediction hit, gating switch, compression) are counted only on cycles inside the window. Each count saturates at 2^CNT_W-1 and does not wrap. All counts clear on the edge that opens a new window.
- R4: There are five Q8 ratios: H = hops/flits, P = hits/predictions, pr = predictions/flits, gr = gating switches/flits and cr = compressions/flits. Each ratio is floor(num*256/den). A zero denominator gives 0.
- R5: Write mq(a,b) = floor(a*b/256). The baseline latency is L0 = 2*LAT_NI + mq(LAT_ROUTE,H) + mq(LAT_LINK,H+256). With prediction, the routing term becomes mq(mq(LAT_SWITCH,P)+mq(LAT_ROUTE,256-P),H). With gating, the latency is L0 + mq(LAT_WAKE,H). With compression, the latency is L0.
- R6: The baseline dynamic energy is E0 = mq(E_ROUTE,H) + mq(E_LINK,H+256). With prediction, the energy is E0 + mq(E_PRED,pr). With gating, the energy is E0 + 2*mq(E_SWITCH,gr). With compression, the energy is mq(E0,COMP_INV) + mq(E_COMP,cr), where COMP_INV is the Q8 reciprocal of the compression ratio.
- R7: A feature is enabled for the epoch only if (latency x energy) with the feature is strictly less than the baseline product; a tie leaves it off. The baseline product for prediction and compression is L0*E0. For gating it is L0*(E0+E_GATE_SAVE).
- R8: The hit rate P is clamped to 256 (1.0) before it is used, so a hit count larger than the prediction count acts as a perfect hit rate.
- R9: The enables take the new decision exactly 5*(CNT_W+10)+1 clock cycles after the edge that closes the window.
- R10: The enables stay constant for EPOCH_LEN `instr_ret` pulses counted from the start of the epoch. Instruction pulses and events during the computation phase, and events during the epoch, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_ret | input | 1 | One retired instruction per high cycle |
| ev_flit | input | 1 | Flit injected event pulse |
| ev_hop | input | 1 | Flit hop (router traversal) event pulse |
| ev_pred | input | 1 | Port prediction made event pulse |
| ev_pred_hit | input | 1 | Port prediction correct event pulse |
| ev_gate_sw | input | 1 | Router power switch event pulse |
| ev_comp | input | 1 | Packet compressed event pulse |
| en_gate | output | 1 | Power gating enable |
| en_pred | output | 1 | Port prediction enable |
| en_comp | output | 1 | Traffic compression enable |

## Verification
The bench runs six windows that target distinct corners, each checked against a behavioural reference on every cycle. One window drives exactly a compression tie, so a design that uses less-or-equal turns compression on. One window has more hits than predictions, so a design without the hit-rate clamp underflows the miss term and turns prediction off. One window has no flits, so a design with a wrong zero-denominator result produces garbage ratios. One window has flits past the counter limit and a gating rate near the threshold, so a counter that wraps flips the gating decision. Events are asserted throughout every computation phase and epoch, so a design that counts them, or miscounts the computation latency, disagrees with the reference at the phase edges.

// File: rtl/noc_gov_pkg.sv
package noc_gov_pkg;

    localparam int VAL_W  = 40;
    localparam int NEV    = 6;
    localparam int NDIV   = 5;
    localparam int Q8_ONE = 256;

    localparam int EV_FLIT = 0;
    localparam int EV_HOP  = 1;
    localparam int EV_PRED = 2;
    localparam int EV_HIT  = 3;
    localparam int EV_GATE = 4;
    localparam int EV_COMP = 5;

    typedef logic [VAL_W-1:0]   val_t;
    typedef logic [2*VAL_W-1:0] wide_t;

    typedef enum logic [1:0] {
        PH_WIN   = 2'd0,
        PH_CALC  = 2'd1,
        PH_EPOCH = 2'd2
    } phase_e;

    typedef struct packed {
        logic gate;
        logic pred;
        logic comp;
    } feat_t;

    typedef struct packed {
        val_t hop;
        val_t hit;
        val_t pred;
        val_t gate;
        val_t comp;
    } ratios_t;

    function automatic val_t mulq(val_t a, val_t b);
        wide_t p;
        p = wide_t'(a) * wide_t'(b);
        return p[VAL_W+7:8];
    endfunction

endpackage

// File: rtl/noc_gov_counters.sv
module noc_gov_counters #(
    parameter int NUM = 6,
    parameter int CW  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   cnt_en,
    input  logic [NUM-1:0]         ev,
    output logic [NUM-1:0][CW-1:0] cnt
);

    logic [CW-1:0] c_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                c_q[g] <= '0;
            end else if (cnt_en && ev[g] && (c_q[g] != '1)) begin
                c_q[g] <= c_q[g] + 1'b1;
            end
        end

        assign cnt[g] = c_q[g];

        assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!clr && c_q[g] == '1) |=> (c_q[g] == '1));

        assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
            clr |=> (c_q[g] == '0));

        assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
            (!cnt_en && !clr) |=> $stable(c_q[g]));
    end

endmodule

// File: rtl/noc_gov_divider.sv
module noc_gov_divider #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] num,
    input  logic [CW-1:0] den,
    output logic [CW+7:0] quo,
    output logic          done
);

    localparam int QW = CW + 8;
    localparam int SW = $clog2(QW + 1);

    logic [QW-1:0] q;
    logic [CW-1:0] rem;
    logic [SW-1:0] steps;
    logic          busy;
    logic          zero_den;
    logic [CW:0]   trial;

    assign trial = {rem, q[QW-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            rem      <= '0;
            steps    <= '0;
            busy     <= 1'b0;
            zero_den <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q        <= {num, 8'd0};
                rem      <= '0;
                steps    <= SW'(QW);
                busy     <= 1'b1;
                zero_den <= (den == '0);
            end else if (busy) begin
                if (trial >= {1'b0, den}) begin
                    rem <= CW'(trial - {1'b0, den});
                    q   <= {q[QW-2:0], 1'b1};
                end else begin
                    rem <= trial[CW-1:0];
                    q   <= {q[QW-2:0], 1'b0};
                end
                steps <= steps - 1'b1;
                if (steps == SW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = zero_den ? '0 : q;

    assert_div_run_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_div_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_div_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/noc_gov_model.sv
module noc_gov_model
    import noc_gov_pkg::*;
#(
    parameter int unsigned LAT_NI      = 256,
    parameter int unsigned LAT_ROUTE   = 768,
    parameter int unsigned LAT_SWITCH  = 256,
    parameter int unsigned LAT_LINK    = 256,
    parameter int unsigned LAT_WAKE    = 512,
    parameter int unsigned E_ROUTE     = 512,
    parameter int unsigned E_LINK      = 256,
    parameter int unsigned E_SWITCH    = 1024,
    parameter int unsigned E_PRED      = 128,
    parameter int unsigned E_COMP      = 256,
    parameter int unsigned COMP_INV    = 128,
    parameter int unsigned E_GATE_SAVE = 2048
) (
    input  ratios_t rat,
    output feat_t   dec
);

    val_t  h, hp1, p, l_link, l0, e0;
    val_t  lg, eg, eg_base, route_p, lp, ep, ec;
    wide_t base;

    always_comb begin
        h       = rat.hop;
        hp1     = h + val_t'(Q8_ONE);
        p       = (rat.hit > val_t'(Q8_ONE)) ? val_t'(Q8_ONE) : rat.hit;
        l_link  = mulq(val_t'(LAT_LINK), hp1);
        l0      = val_t'(2 * LAT_NI) + mulq(val_t'(LAT_ROUTE), h) + l_link;
        e0      = mulq(val_t'(E_ROUTE), h) + mulq(val_t'(E_LINK), hp1);
        base    = wide_t'(l0) * wide_t'(e0);

        lg      = l0 + mulq(val_t'(LAT_WAKE), h);
        eg      = e0 + (mulq(val_t'(E_SWITCH), rat.gate) << 1);
        eg_base = e0 + val_t'(E_GATE_SAVE);

        route_p = mulq(val_t'(LAT_SWITCH), p)
                + mulq(val_t'(LAT_ROUTE), val_t'(Q8_ONE) - p);
        lp      = val_t'(2 * LAT_NI) + mulq(route_p, h) + l_link;
        ep      = e0 + mulq(val_t'(E_PRED), rat.pred);

        ec      = mulq(e0, val_t'(COMP_INV)) + mulq(val_t'(E_COMP), rat.comp);

        dec.gate = (wide_t'(lg) * wide_t'(eg)) < (wide_t'(l0) * wide_t'(eg_base));
        dec.pred = (wide_t'(lp) * wide_t'(ep)) < base;
        dec.comp = (wide_t'(l0) * wide_t'(ec)) < base;
    end

endmodule

// File: rtl/noc_feature_governor.sv
module noc_feature_governor
    import noc_gov_pkg::*;
#(
    parameter int          WIN_LEN     = 10000,
    parameter int          EPOCH_LEN   = 200000,
    parameter int          CNT_W       = 16,
    parameter int unsigned LAT_NI      = 256,
    parameter int unsigned LAT_ROUTE   = 768,
    parameter int unsigned LAT_SWITCH  = 256,
    parameter int unsigned LAT_LINK    = 256,
    parameter int unsigned LAT_WAKE    = 512,
    parameter int unsigned E_ROUTE     = 512,
    parameter int unsigned E_LINK      = 256,
    parameter int unsigned E_SWITCH    = 1024,
    parameter int unsigned E_PRED      = 128,
    parameter int unsigned E_COMP      = 256,
    parameter int unsigned COMP_INV    = 128,
    parameter int unsigned E_GATE_SAVE = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic instr_ret,
    input  logic ev_flit,
    input  logic ev_hop,
    input  logic ev_pred,
    input  logic ev_pred_hit,
    input  logic ev_gate_sw,
    input  logic ev_comp,
    output logic en_gate,
    output logic en_pred,
    output logic en_comp
);

    localparam int MAXLEN = (WIN_LEN > EPOCH_LEN) ? WIN_LEN : EPOCH_LEN;
    localparam int IW     = $clog2(MAXLEN + 1);
    localparam int QW     = CNT_W + 8;
    localparam logic [IW-1:0] WIN_LAST   = IW'(WIN_LEN - 1);
    localparam logic [IW-1:0] EPOCH_LAST = IW'(EPOCH_LEN - 1);
    localparam logic [2:0]    IDX_LAST   = 3'(NDIV - 1);

    phase_e                       phase;
    logic [IW-1:0]                icnt;
    logic [2:0]                   idx;
    logic                         div_go, div_done, eval_q;
    logic [QW-1:0]                div_q;
    logic [CNT_W-1:0]             div_num, div_den;
    logic [NEV-1:0]               ev;
    logic [NEV-1:0][CNT_W-1:0]    cnt;
    ratios_t                      rat;
    feat_t                        dec, en_q;
    logic                         win_end, epoch_end;

    assign ev = {ev_comp, ev_gate_sw, ev_pred_hit, ev_pred, ev_hop, ev_flit};
    assign win_end   = (phase == PH_WIN)   && instr_ret && (icnt == WIN_LAST);
    assign epoch_end = (phase == PH_EPOCH) && instr_ret && (icnt == EPOCH_LAST);

    noc_gov_counters #(.NUM(NEV), .CW(CNT_W)) u_ctrs (
        .clk    (clk),
        .rst    (rst),
        .clr    (epoch_end),
        .cnt_en (phase == PH_WIN),
        .ev     (ev),
        .cnt    (cnt)
    );

    always_comb begin
        case (idx)
            3'd1:    begin div_num = cnt[EV_HIT];  div_den = cnt[EV_PRED]; end
            3'd2:    begin div_num = cnt[EV_PRED]; div_den = cnt[EV_FLIT]; end
            3'd3:    begin div_num = cnt[EV_GATE]; div_den = cnt[EV_FLIT]; end
            3'd4:    begin div_num = cnt[EV_COMP]; div_den = cnt[EV_FLIT]; end
            default: begin div_num = cnt[EV_HOP];  div_den = cnt[EV_FLIT]; end
        endcase
    end

    noc_gov_divider #(.CW(CNT_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_go),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_q),
        .done  (div_done)
    );

    noc_gov_model #(
        .LAT_NI(LAT_NI), .LAT_ROUTE(LAT_ROUTE), .LAT_SWITCH(LAT_SWITCH),
        .LAT_LINK(LAT_LINK), .LAT_WAKE(LAT_WAKE), .E_ROUTE(E_ROUTE),
        .E_LINK(E_LINK), .E_SWITCH(E_SWITCH), .E_PRED(E_PRED),
        .E_COMP(E_COMP), .COMP_INV(COMP_INV), .E_GATE_SAVE(E_GATE_SAVE)
    ) u_model (
        .rat (rat),
        .dec (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_WIN;
            icnt   <= '0;
            idx    <= '0;
            div_go <= 1'b0;
            eval_q <= 1'b0;
            rat    <= '0;
            en_q   <= '1;
        end else begin
            div_go <= 1'b0;
            eval_q <= 1'b0;
            case (phase)
                PH_WIN: begin
                    if (win_end) begin
                        icnt   <= '0;
                        idx    <= '0;
                        div_go <= 1'b1;
                        phase  <= PH_CALC;
                    end else if (instr_ret) begin
                        icnt <= icnt + 1'b1;
                    end
                end
                PH_CALC: begin
                    if (div_done) begin
                        case (idx)
                            3'd0:    rat.hop  <= val_t'(div_q);
                            3'd1:    rat.hit  <= val_t'(div_q);
                            3'd2:    rat.pred <= val_t'(div_q);
                            3'd3:    rat.gate <= val_t'(div_q);
                            default: rat.comp <= val_t'(div_q);
                        endcase
                        if (idx == IDX_LAST) begin
                            eval_q <= 1'b1;
                        end else begin
                            idx    <= idx + 1'b1;
                            div_go <= 1'b1;
                        end
                    end
                    if (eval_q) begin
                        en_q  <= dec;
                        phase <= PH_EPOCH;
                    end
                end
                default: begin
                    if (epoch_end) begin
                        icnt  <= '0;
                        en_q  <= '1;
                        phase <= PH_WIN;
                    end else if (instr_ret) begin
                        icnt <= icnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign en_gate = en_q.gate;
    assign en_pred = en_q.pred;
    assign en_comp = en_q.comp;

    assert_all_on_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EPOCH) |-> (en_gate && en_pred && en_comp));

    assert_win_close_R2: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (phase == PH_CALC));

    assert_epoch_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_EPOCH) && !epoch_end) |=> $stable(en_q));

    assert_epoch_close_R10: assert property (@(posedge clk) disable iff (rst)
        epoch_end |=> (phase == PH_WIN));

endmodule

// File: tb/noc_feature_governor_tb.sv
module noc_feature_governor_tb;

    localparam int WIN   = 30;
    localparam int EPO   = 40;
    localparam int CW    = 6;
    localparam int KLAT  = 5 * (CW + 10) + 1;
    localparam int NSC   = 6;
    localparam longint SATV = (64'd1 << CW) - 1;

    localparam longint C_NI = 256, C_RT = 768, C_ST = 256, C_LK = 256, C_WK = 512;
    localparam longint C_ER = 512, C_EL = 256, C_ES = 1024, C_EP = 128, C_EC = 256;
    localparam longint C_CI = 128, C_GS = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic instr_ret = 1'b0;
    logic ev_flit = 1'b0, ev_hop = 1'b0, ev_pred = 1'b0;
    logic ev_pred_hit = 1'b0, ev_gate_sw = 1'b0, ev_comp = 1'b0;
    logic en_gate, en_pred, en_comp;

    always #10 clk = ~clk;

    noc_feature_governor #(
        .WIN_LEN(WIN), .EPOCH_LEN(EPO), .CNT_W(CW),
        .LAT_NI(256), .LAT_ROUTE(768), .LAT_SWITCH(256), .LAT_LINK(256),
        .LAT_WAKE(512), .E_ROUTE(512), .E_LINK(256), .E_SWITCH(1024),
        .E_PRED(128), .E_COMP(256), .COMP_INV(128), .E_GATE_SAVE(2048)
    ) u_dut (
        .clk(clk), .rst(rst), .instr_ret(instr_ret),
        .ev_flit(ev_flit), .ev_hop(ev_hop), .ev_pred(ev_pred),
        .ev_pred_hit(ev_pred_hit), .ev_gate_sw(ev_gate_sw), .ev_comp(ev_comp),
        .en_gate(en_gate), .en_pred(en_pred), .en_comp(en_comp)
    );

    // Scenario table: event pulses per window (first n window cycles), instr period
    int sc_flit[NSC] = '{10, 5, 2, 10, 0, 90};
    int sc_hop [NSC] = '{20, 10, 4, 20, 20, 60};
    int sc_pred[NSC] = '{10, 10, 0, 2, 5, 0};
    int sc_hit [NSC] = '{10, 0, 0, 10, 3, 0};
    int sc_gate[NSC] = '{0, 10, 0, 0, 5, 20};
    int sc_comp[NSC] = '{10, 30, 7, 0, 5, 0};
    int sc_ipr [NSC] = '{1, 1, 1, 1, 1, 3};
    string sc_tag[NSC] = '{"R5 R6", "R7", "R7 tie", "R8", "R4", "R3"};

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Behavioural reference state
    int     r_phase;   // 0 window, 1 compute, 2 epoch
    int     r_wc, r_ic, r_cc, r_win_no;
    longint r_cnt[6];  // flit hop pred hit gate comp
    logic [2:0] r_en, r_dec;

    function automatic longint mq(longint a, longint b);
        return (a * b) >> 8;
    endfunction

    function automatic longint qd(longint n, longint d);
        return (d == 0) ? 0 : (n * 256) / d;
    endfunction

    function automatic logic [2:0] decide(longint c[6]);
        longint h, p, pr, gr, cr, hp1, ll, l0, e0, lp;
        logic g, pp, cc;
        h  = qd(c[1], c[0]);
        p  = qd(c[3], c[2]);
        if (p > 256) p = 256;           // R8 clamp
        pr = qd(c[2], c[0]);
        gr = qd(c[4], c[0]);
        cr = qd(c[5], c[0]);
        hp1 = h + 256;
        ll  = mq(C_LK, hp1);
        l0  = 2 * C_NI + mq(C_RT, h) + ll;
        e0  = mq(C_ER, h) + mq(C_EL, hp1);
        g   = ((l0 + mq(C_WK, h)) * (e0 + 2 * mq(C_ES, gr))) < (l0 * (e0 + C_GS));
        lp  = 2 * C_NI + mq(mq(C_ST, p) + mq(C_RT, 256 - p), h) + ll;
        pp  = (lp * (e0 + mq(C_EP, pr))) < (l0 * e0);
        cc  = (l0 * (mq(e0, C_CI) + mq(C_EC, cr))) < (l0 * e0);
        return {g, pp, cc};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            r_phase = 0; r_wc = 0; r_ic = 0; r_cc = 0; r_win_no = 0;
            for (int i = 0; i < 6; i++) r_cnt[i] = 0;
            r_en = 3'b111;
        end else begin
            case (r_phase)
                0: begin
                    if (ev_flit     && r_cnt[0] < SATV) r_cnt[0]++;
                    if (ev_hop      && r_cnt[1] < SATV) r_cnt[1]++;
                    if (ev_pred     && r_cnt[2] < SATV) r_cnt[2]++;
                    if (ev_pred_hit && r_cnt[3] < SATV) r_cnt[3]++;
                    if (ev_gate_sw  && r_cnt[4] < SATV) r_cnt[4]++;
                    if (ev_comp     && r_cnt[5] < SATV) r_cnt[5]++;
                    r_wc++;
                    if (instr_ret) begin
                        if (r_ic == WIN - 1) begin
                            r_dec   = decide(r_cnt);
                            r_phase = 1; r_cc = 0; r_ic = 0;
                        end else r_ic++;
                    end
                end
                1: begin
                    r_cc++;
                    if (r_cc == KLAT) begin
                        r_en = r_dec; r_phase = 2; r_ic = 0;
                    end
                end
                default: begin
                    if (instr_ret) begin
                        if (r_ic == EPO - 1) begin
                            r_phase = 0; r_en = 3'b111; r_ic = 0; r_wc = 0;
                            r_win_no++;
                            for (int i = 0; i < 6; i++) r_cnt[i] = 0;
                        end else r_ic++;
                    end
                end
            endcase
        end
    end

    task automatic check_en(string tag);
        logic [2:0] act;
        act = {en_gate, en_pred, en_comp};
        checks++;
        if (act !== r_en) begin
            fails++;
            $display("FAIL %s cycle %0d: enables {gate,pred,comp} = %b, expected %b",
                     tag, cyc, act, r_en);
        end
    endtask

    task automatic drive_inputs();
        int s;
        s = (r_win_no < NSC) ? r_win_no : NSC - 1;
        if (r_phase == 0) begin
            instr_ret   = (r_wc % sc_ipr[s]) == 0;
            ev_flit     = r_wc < sc_flit[s];
            ev_hop      = r_wc < sc_hop[s];
            ev_pred     = r_wc < sc_pred[s];
            ev_pred_hit = r_wc < sc_hit[s];
            ev_gate_sw  = r_wc < sc_gate[s];
            ev_comp     = r_wc < sc_comp[s];
        end else begin
            // R10: pulses outside the window must have no effect
            instr_ret = 1'b1;
            ev_flit = 1'b1; ev_hop = 1'b1; ev_pred = 1'b1;
            ev_pred_hit = 1'b1; ev_gate_sw = 1'b1; ev_comp = 1'b1;
        end
    endtask

    initial begin
        bit done;
        done = 1'b0;
        repeat (3) @(negedge clk);
        check_en("R1");                 // reset state: all enables on
        drive_inputs();
        rst = 1'b0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (r_phase == 0)      check_en("R2");
            else if (r_phase == 1) check_en("R9");
            else                   check_en({sc_tag[r_win_no < NSC ? r_win_no : NSC-1], " R10"});
            if (r_win_no >= NSC) done = 1'b1;
            else if (cyc > 20000) begin
                fails++;
                checks++;
                $display("FAIL watchdog R10: run did not finish, cycles %0d, expected under %0d",
                         cyc, 20000);
                done = 1'b1;
            end
            drive_inputs();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule